// File: doc/BRIEF.md
# Programmable Chopper Clock Generator

This block derives two auxiliary square-wave clocks from the master system clock. A 2-bit fast select picks one of three fast rates for the fast output, or holds it high. A 4-bit slow select picks one rung of an even-division ladder for the slow output, or holds it high. Both outputs run at 50% duty cycle. Each comes from a half-period counter whose reload value is worked out at elaboration from the master clock frequency parameter.

A select change never cuts a pulse short. While an output is toggling, the new value is adopted only at its next rising edge, so the phase in progress always runs to its full length. An output that is held high picks up a new non-idle rate on the next master clock edge, and its first high phase is a full half-period. Reset forces both outputs high.

Top module: `chop_clk_gen`

## Requirements
- R1: While reset is asserted, and right after it is released with both selects at zero, both outputs are high.
- R2: Fast select 00 holds the fast output constantly high.
- R3: Fast select 01 gives FAST_LO_HZ (256 kHz). High and low phases are each CLK_HZ/(2*FAST_LO_HZ) master cycles, which is 64 at 32.768 MHz.
- R4: Fast select 10 gives twice FAST_LO_HZ (512 kHz). High and low phases are each 32 master cycles at 32.768 MHz.
- R5: Fast select 11 gives FAST_HI_HZ (16.384 MHz). High and low phases are each 1 master cycle at 32.768 MHz.
- R6: Slow select 0000 holds the slow output constantly high.
- R7: Slow select N, for N = 1 to 8, gives SLOW_BASE_HZ/(2N). High and low phases are each N*CLK_HZ/SLOW_BASE_HZ master cycles.
- R8: Slow select values 1001 through 1111 act like 0000, and the slow output stays constantly high.
- R9: Changing a select while its output toggles leaves the current high and low phases at the old length. The new rate starts at the next rising edge. From the constant-high state, a new rate starts on the next master clock edge, and its first high phase lasts a full new half-period.

Divider contract: a select is sampled only at the clock edges where it can take effect. CLK_HZ must be divisible by twice each fast rate and by SLOW_BASE_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_sel_i | input | 2 | Fast output rate select |
| slow_sel_i | input | 4 | Slow output rate select |
| fast_clk_o | output | 1 | Fast auxiliary clock |
| slow_clk_o | output | 1 | Slow auxiliary clock |

## Verification
The assertions assume two things about the inputs. First, the selects are synchronous to the master clock. Second, the parameters divide evenly, so every non-idle code maps to a half-period of at least one cycle. The bench changes selects only on falling clock edges. It sets CLK_HZ to 32.768 MHz and raises SLOW_BASE_HZ to 128 kHz, which scales the slow ladder to 256*N cycles per phase. Every code then yields a non-zero integer half-period and the run stays short.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    FAST_IDLE = 2'd0,
    FAST_LO   = 2'd1,
    FAST_MID  = 2'd2,
    FAST_HI   = 2'd3
  } fast_sel_e;

  localparam int SLOW_STEPS = 8;
  localparam int SLOW_CODES = 16;

  function automatic int half_cycles(input int clk_hz, input int out_hz);
    return clk_hz / (2 * out_hz);
  endfunction
endpackage

// File: rtl/chop_fast_decode.sv
module chop_fast_decode import chop_pkg::*; #(
  parameter int CLK_HZ     = 32_768_000,
  parameter int FAST_LO_HZ = 256_000,
  parameter int FAST_HI_HZ = 16_384_000,
  parameter int HALF_W     = 7
) (
  input  logic [1:0]        sel_i,
  output logic [HALF_W-1:0] half_o
);
  localparam int HALF_LO  = half_cycles(CLK_HZ, FAST_LO_HZ);
  localparam int HALF_MID = half_cycles(CLK_HZ, 2 * FAST_LO_HZ);
  localparam int HALF_HI  = half_cycles(CLK_HZ, FAST_HI_HZ);

  always_comb begin
    unique case (fast_sel_e'(sel_i))
      FAST_LO:  half_o = HALF_W'(HALF_LO);
      FAST_MID: half_o = HALF_W'(HALF_MID);
      FAST_HI:  half_o = HALF_W'(HALF_HI);
      default:  half_o = '0;
    endcase
  end
endmodule

// File: rtl/chop_slow_decode.sv
module chop_slow_decode import chop_pkg::*; #(
  parameter int CLK_HZ       = 32_768_000,
  parameter int SLOW_BASE_HZ = 1000,
  parameter int HALF_W       = 19
) (
  input  logic [3:0]        sel_i,
  output logic [HALF_W-1:0] half_o
);
  localparam int UNIT = CLK_HZ / SLOW_BASE_HZ;

  logic [HALF_W-1:0] ladder [SLOW_CODES];

  // rung N lasts N units per phase; codes past the ladder idle high
  for (genvar gi = 0; gi < SLOW_CODES; gi++) begin : g_rung
    if (gi >= 1 && gi <= SLOW_STEPS) begin : g_on
      assign ladder[gi] = HALF_W'(gi * UNIT);
    end else begin : g_off
      assign ladder[gi] = '0;
    end
  end

  assign half_o = ladder[sel_i];
endmodule

// File: rtl/chop_div.sv
module chop_div #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  output logic              clk_o
);
  logic [HALF_W-1:0] cur_q, cnt_q;
  logic              out_q;
  logic              idle, phase_end, at_rise;

  assign idle      = (cur_q == '0);
  assign phase_end = (cnt_q == cur_q - HALF_W'(1));
  assign at_rise   = phase_end && !out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (idle) begin
      cur_q <= half_i;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (phase_end) begin
      cnt_q <= '0;
      out_q <= !out_q;
      // new rate only adopted on a rising edge
      if (at_rise) cur_q <= half_i;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign clk_o = out_q;

  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> clk_o);

  // R9
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !at_rise) |=> $stable(cur_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |-> (cnt_q < cur_q));

  // R9
  rise_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> (cnt_q == '0));
endmodule

// File: rtl/chop_clk_gen.sv
module chop_clk_gen import chop_pkg::*; #(
  parameter int CLK_HZ       = 32_768_000,
  parameter int FAST_LO_HZ   = 256_000,
  parameter int FAST_HI_HZ   = 16_384_000,
  parameter int SLOW_BASE_HZ = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fast_sel_i,
  input  logic [3:0] slow_sel_i,
  output logic       fast_clk_o,
  output logic       slow_clk_o
);
  localparam int FAST_MAX = half_cycles(CLK_HZ, FAST_LO_HZ);
  localparam int SLOW_MAX = SLOW_STEPS * (CLK_HZ / SLOW_BASE_HZ);
  localparam int FAST_W   = $clog2(FAST_MAX + 1);
  localparam int SLOW_W   = $clog2(SLOW_MAX + 1);

  logic [FAST_W-1:0] fast_half;
  logic [SLOW_W-1:0] slow_half;

  chop_fast_decode #(
    .CLK_HZ(CLK_HZ), .FAST_LO_HZ(FAST_LO_HZ),
    .FAST_HI_HZ(FAST_HI_HZ), .HALF_W(FAST_W)
  ) u_fast_dec (
    .sel_i (fast_sel_i),
    .half_o(fast_half)
  );

  chop_slow_decode #(
    .CLK_HZ(CLK_HZ), .SLOW_BASE_HZ(SLOW_BASE_HZ), .HALF_W(SLOW_W)
  ) u_slow_dec (
    .sel_i (slow_sel_i),
    .half_o(slow_half)
  );

  chop_div #(.HALF_W(FAST_W)) u_fast_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .half_i(fast_half),
    .clk_o (fast_clk_o)
  );

  chop_div #(.HALF_W(SLOW_W)) u_slow_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .half_i(slow_half),
    .clk_o (slow_clk_o)
  );

  // R2
  fast_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_sel_i == 2'd0) |-> (fast_half == '0));

  // R6
  slow_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_sel_i == 4'd0) |-> (slow_half == '0));

  // R8
  slow_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_sel_i > 4'd8) |-> (slow_half == '0));

  // R7
  slow_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_sel_i != 4'd0 && slow_sel_i <= 4'd8) |-> (slow_half != '0));
endmodule

// File: tb/sim_chop_clk_gen.sv
`timescale 1ns/1ps
module sim_chop_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fast_sel = 2'd0;
  logic [3:0] slow_sel = 4'd0;
  logic       fast_clk, slow_clk;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = !clk;

  chop_clk_gen #(
    .CLK_HZ(32_768_000), .FAST_LO_HZ(256_000),
    .FAST_HI_HZ(16_384_000), .SLOW_BASE_HZ(128_000)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fast_sel_i(fast_sel), .slow_sel_i(slow_sel),
    .fast_clk_o(fast_clk), .slow_clk_o(slow_clk)
  );

  // fast sel, slow sel, fast half, slow half (0 = constant high)
  localparam int VEC [11][4] = '{
    '{1, 1, 64, 256},  '{2, 2, 32, 512},  '{3, 3, 1, 768},
    '{0, 4, 0, 1024},  '{1, 5, 64, 1280}, '{2, 6, 32, 1536},
    '{3, 7, 1, 1792},  '{1, 8, 64, 2048}, '{2, 9, 32, 0},
    '{3, 15, 1, 0},    '{0, 0, 0, 0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pick(input bit slow);
    return slow ? slow_clk : fast_clk;
  endfunction

  task automatic wait_rise(input bit slow, output bit ok);
    bit prev = pick(slow);
    ok = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (pick(slow) && !prev) begin ok = 1; return; end
      prev = pick(slow);
    end
  endtask

  // at a negedge where the output was just seen rising
  task automatic phases(input bit slow, output int h, output int l);
    h = 1; l = 0;
    while (h < 10000) begin
      @(negedge clk);
      if (!pick(slow)) break;
      h++;
    end
    l = 1;
    while (l < 10000) begin
      @(negedge clk);
      if (pick(slow)) break;
      l++;
    end
  endtask

  task automatic measure(input bit slow, input int exp, input string tag);
    bit ok; int h, l;
    wait_rise(slow, ok);
    chk(ok, {tag, " rise"}, ok, 1);
    if (!ok) return;
    phases(slow, h, l);
    chk(h >= exp - 1 && h <= exp + 1, {tag, " high"}, h, exp);
    chk(l >= exp - 1 && l <= exp + 1, {tag, " low"}, l, exp);
  endtask

  task automatic const_high(input bit slow, input string tag);
    int lows = 0;
    repeat (4200) @(negedge clk);
    repeat (600) begin
      @(negedge clk);
      if (!pick(slow)) lows++;
    end
    chk(lows == 0, tag, lows, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, l, n;
    bit ok;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    chk(fast_clk && slow_clk, "R1 in reset", {fast_clk, slow_clk}, 3);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(fast_clk && slow_clk, "R1 after reset", {fast_clk, slow_clk}, 3);

    for (int v = 0; v < 11; v++) begin
      fast_sel = 2'(VEC[v][0]);
      slow_sel = 4'(VEC[v][1]);
      if (VEC[v][2] == 0) const_high(0, "R2 fast idle");
      else if (VEC[v][0] == 1) measure(0, VEC[v][2], "R3 fast 256k");
      else if (VEC[v][0] == 2) measure(0, VEC[v][2], "R4 fast 512k");
      else measure(0, VEC[v][2], "R5 fast 16M");
      if (VEC[v][3] != 0) measure(1, VEC[v][3], "R7 slow ladder");
      else if (VEC[v][1] == 0) const_high(1, "R6 slow idle");
      else const_high(1, "R8 slow unused code");
    end

    // R9 start from constant high: full first high phase
    fast_sel = 2'd0;
    repeat (10) @(negedge clk);
    fast_sel = 2'd1;
    n = 0;
    while (n < 1000) begin
      @(negedge clk);
      if (!fast_clk) break;
      n++;
    end
    chk(n >= 63 && n <= 65, "R9 start from idle", n, 64);

    // R9 mid-phase change keeps old phases, new rate after rise
    wait_rise(0, ok);
    h = 1;
    while (h < 1000) begin
      @(negedge clk);
      if (h == 10) fast_sel = 2'd2;
      if (!fast_clk) break;
      h++;
    end
    l = 1;
    while (l < 1000) begin
      @(negedge clk);
      if (fast_clk) break;
      l++;
    end
    chk(h >= 63 && h <= 65, "R9 old high kept", h, 64);
    chk(l >= 63 && l <= 65, "R9 old low kept", l, 64);
    phases(0, h, l);
    chk(h >= 31 && h <= 33, "R9 new high", h, 32);
    chk(l >= 31 && l <= 33, "R9 new low", l, 32);

    // R1 mid-run reset forces high
    fast_sel = 2'd3;
    slow_sel = 4'd1;
    wait_rise(1, ok);
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(fast_clk && slow_clk, "R1 mid-run reset", {fast_clk, slow_clk}, 3);
    fast_sel = 2'd0;
    slow_sel = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(fast_clk && slow_clk, "R1 post reset idle", {fast_clk, slow_clk}, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule